// File: doc/BRIEF.md
# Monochrome Hardware Cursor Overlay

This block lays a 64x64 two-plane cursor image over a 32-bit pixel stream on its way to the display. Software programs the cursor through a small write-only register port: an image base address, a screen position, a hotspot adjustment, two 24-bit colours, an enable bit and a lock bit that holds back changes until they are complete.

Ahead of each scanline, the timing logic announces the upcoming line number with a one-cycle request. If that line crosses the cursor, the block reads the matching 16-byte image row from a byte-wide memory read port, one byte per cycle with one cycle of read latency, into a small line buffer. During active video, each incoming background pixel arrives with its x and y coordinates. One cycle later the block emits either that pixel unchanged or the pixel blended from the two mask bits. Pixels are clipped at the right edge of the visible line and below the last visible line.

Top module: `hwcur_overlay`

## Requirements
- R1: `out_valid` is `pix_valid` delayed by exactly one clock. Where no cursor pixel applies, `out_rgb` equals the `pix_rgb` accepted one clock earlier.
- R2: A cursor image row is 16 bytes long. Bytes 0..7 form the AND plane and bytes 8..15 form the XOR plane. Cursor column c uses bit 7-(c mod 8) of byte c/8 in each plane, so the most significant bit comes first. A request for a cursor line makes exactly 16 reads, at start + row*16 + i for i = 0..15 in order. A request for any other line makes no reads.
- R3: When the AND bit is 1 and the XOR bit is 1, the output is the bitwise complement of all 32 bits of the background.
- R4: When the AND bit is 1 and the XOR bit is 0, the background passes unchanged.
- R5: When the AND bit is 0, the output is {8'hFF, colour1} if the XOR bit is 1 and {8'hFF, colour0} if it is 0.
- R6: The row-0 start address is (base & 0x07FFFFF0) - hx - 16*hy, taken modulo 2^ADDR_W. hx is the hotspot register field [21:16] and hy is field [5:0].
- R7: Bit 31 of the base register is a lock. While it is set, writes to base, position, hotspot and colours are only recorded. Clearing the bit applies all recorded values together.
- R8: Register select values are 0 control (bit 0 is the enable), 1 base, 2 position, 3 hotspot, 4 colour0 and 5 colour1. Writes keep base bits under 0x87FFFFF0, position bits under 0x3FFF0FFF (x in [29:16], y in [11:0]), hotspot bits under 0x003F003F, and colour bits [23:0].
- R9: Cursor pixels appear only where x < (disp_hfield + 1) * 8. Past that edge the background passes, and the cursor does not wrap.
- R10: Cursor pixels appear only on lines y0..y0+63 that are also at or above `disp_vlast`, where y0 is the cursor y position.
- R11: While the enable bit is clear, no cursor pixel is produced and no row is fetched.
- R12: Pixels of a line that arrive before the line's 16-byte fetch has completed pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| disp_hfield | input | H_W | Visible width in units of 8 pixels, minus one |
| disp_vlast | input | Y_W | Last visible line |
| line_req | input | 1 | Pulse announcing the next line |
| line_y | input | Y_W | Number of the announced line |
| pix_valid | input | 1 | Background pixel valid |
| pix_x | input | X_W | Pixel column |
| pix_y | input | Y_W | Pixel line |
| pix_rgb | input | 32 | Background pixel |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 32 | Blended pixel |
| mem_rd_en | output | 1 | Cursor memory read strobe |
| mem_addr | output | ADDR_W | Cursor memory byte address |
| mem_rdata | input | 8 | Read data, valid one clock after the strobe |

## Verification
The bench builds the block with ADDR_W = 12, so its memory model is a 4096-byte address-hashed pattern that the bench computes itself. With that width, the hotspot subtraction can wrap below address zero. X_W and Y_W stay at 14 and 12, the widths the position register masks imply. A 64-pixel cursor then reaches both the right clip edge and the last visible line at small coordinates, which keeps scanlines short.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;
  localparam int unsigned CUR_DIM     = 64;
  localparam int unsigned ROW_BYTES   = 16;
  localparam int unsigned PLANE_BYTES = 8;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_BASE = 3'd1,
    SEL_POS  = 3'd2,
    SEL_HOT  = 3'd3,
    SEL_CLR0 = 3'd4,
    SEL_CLR1 = 3'd5
  } reg_sel_e;

  localparam logic [31:0] BASE_KEEP = 32'h87FF_FFF0;
  localparam logic [31:0] POS_KEEP  = 32'h3FFF_0FFF;
  localparam logic [31:0] HOT_KEEP  = 32'h003F_003F;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] pos;
    logic [31:0] hot;
    logic [23:0] clr0;
    logic [23:0] clr1;
  } cur_cfg_t;
endpackage

// File: rtl/hwcur_regs.sv
module hwcur_regs
  import hwcur_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic        cur_en,
  output cur_cfg_t    cfg_act
);
  cur_cfg_t cfg_pend;
  logic     lock;

  assign lock = cfg_pend.base[31];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_pend <= '0;
      cfg_act  <= '0;
      cur_en   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (reg_sel_e'(wr_sel))
          SEL_CTRL: cur_en        <= wr_data[0];
          SEL_BASE: cfg_pend.base <= wr_data & BASE_KEEP;
          SEL_POS:  cfg_pend.pos  <= wr_data & POS_KEEP;
          SEL_HOT:  cfg_pend.hot  <= wr_data & HOT_KEEP;
          SEL_CLR0: cfg_pend.clr0 <= wr_data[23:0];
          SEL_CLR1: cfg_pend.clr1 <= wr_data[23:0];
          default:  ;
        endcase
      end
      if (!lock) cfg_act <= cfg_pend;
    end
  end

  // R7: a set lock freezes the applied configuration
  a_r7_lock_freezes: assert property (@(posedge clk) disable iff (rst)
    $past(lock) |-> $stable(cfg_act));

  // R8: recorded base never carries bits outside its keep mask
  a_r8_base_mask: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> ((cfg_pend.base & ~BASE_KEEP) == 32'd0));
endmodule

// File: rtl/hwcur_fetch.sv
module hwcur_fetch
  import hwcur_pkg::*;
#(
  parameter int unsigned ADDR_W = 27,
  parameter int unsigned Y_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_req,
  input  logic [Y_W-1:0]    line_y,
  input  logic              cur_en,
  input  logic [Y_W-1:0]    cur_y,
  input  logic [Y_W-1:0]    vis_last,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              row_ok,
  output logic [Y_W-1:0]    row_y,
  input  logic [2:0]        byte_sel,
  output logic [7:0]        and_byte,
  output logic [7:0]        xor_byte
);
  localparam int unsigned IDX_W = $clog2(ROW_BYTES);

  logic [7:0]       lbuf [ROW_BYTES];
  logic             busy;
  logic [IDX_W-1:0] issue_cnt;
  logic             cap_valid;
  logic [IDX_W-1:0] cap_idx;
  logic [Y_W:0]     dy;
  logic             in_rows;

  assign dy      = {1'b0, line_y} - {1'b0, cur_y};
  assign in_rows = cur_en && !dy[Y_W] && (dy[Y_W-1:0] < Y_W'(CUR_DIM)) &&
                   (line_y <= vis_last);
  assign mem_rd_en = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      issue_cnt <= '0;
      cap_valid <= 1'b0;
      cap_idx   <= '0;
      mem_addr  <= '0;
      row_ok    <= 1'b0;
      row_y     <= '0;
    end else if (line_req) begin
      row_ok    <= 1'b0;
      row_y     <= line_y;
      cap_valid <= 1'b0;
      issue_cnt <= '0;
      busy      <= in_rows;
      mem_addr  <= start_addr + ADDR_W'({dy[5:0], 4'b0000});
    end else begin
      cap_valid <= busy;
      cap_idx   <= issue_cnt;
      if (busy) begin
        mem_addr  <= mem_addr + 1'b1;
        issue_cnt <= issue_cnt + 1'b1;
        if (issue_cnt == IDX_W'(ROW_BYTES - 1)) busy <= 1'b0;
      end
      if (cap_valid && cap_idx == IDX_W'(ROW_BYTES - 1)) row_ok <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_valid && !line_req) lbuf[cap_idx] <= mem_rdata;
  end

  assign and_byte = lbuf[{1'b0, byte_sel}];
  assign xor_byte = lbuf[{1'b1, byte_sel}];

  // R2: reads within one row fetch walk consecutive byte addresses
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en) && !$past(line_req)) |->
      (mem_addr == $past(mem_addr) + 1'b1));

  // R11: a request while disabled starts no reads
  a_r11_no_fetch: assert property (@(posedge clk) disable iff (rst)
    (line_req && !cur_en) |=> !mem_rd_en);
endmodule

// File: rtl/hwcur_blend.sv
module hwcur_blend
  import hwcur_pkg::*;
#(
  parameter int unsigned X_W = 14,
  parameter int unsigned Y_W = 12,
  parameter int unsigned H_W = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pix_valid,
  input  logic [X_W-1:0] pix_x,
  input  logic [Y_W-1:0] pix_y,
  input  logic [31:0]    pix_rgb,
  input  logic           cur_en,
  input  logic [X_W-1:0] cur_x,
  input  logic [23:0]    clr0,
  input  logic [23:0]    clr1,
  input  logic [H_W-1:0] hfield,
  input  logic           row_ok,
  input  logic [Y_W-1:0] row_y,
  output logic [2:0]     byte_sel,
  input  logic [7:0]     and_byte,
  input  logic [7:0]     xor_byte,
  output logic           out_valid,
  output logic [31:0]    out_rgb
);
  localparam int unsigned CMP_W = (X_W > H_W + 4) ? X_W + 1 : H_W + 5;

  logic [X_W:0]     dx;
  logic [H_W:0]     hf_p1;
  logic [CMP_W-1:0] vis_w;
  logic [CMP_W-1:0] px_e;
  logic             in_x, on_screen, hit;
  logic [5:0]       col;
  logic [2:0]       bit_idx;
  logic             a_bit, x_bit;
  logic [31:0]      mix;

  assign dx        = {1'b0, pix_x} - {1'b0, cur_x};
  assign in_x      = !dx[X_W] && (dx[X_W-1:0] < X_W'(CUR_DIM));
  assign hf_p1     = {1'b0, hfield} + 1'b1;
  assign vis_w     = CMP_W'({hf_p1, 3'b000});
  assign px_e      = CMP_W'(pix_x);
  assign on_screen = px_e < vis_w;
  assign hit       = cur_en && row_ok && (pix_y == row_y) && in_x && on_screen;
  assign col       = dx[5:0];
  assign byte_sel  = col[5:3];
  assign bit_idx   = 3'd7 - col[2:0];
  assign a_bit     = and_byte[bit_idx];
  assign x_bit     = xor_byte[bit_idx];

  always_comb begin
    mix = pix_rgb;
    if (hit) begin
      case ({a_bit, x_bit})
        2'b11:   mix = ~pix_rgb;
        2'b10:   mix = pix_rgb;
        2'b01:   mix = {8'hFF, clr1};
        default: mix = {8'hFF, clr0};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid) out_rgb <= mix;
    end
  end

  // R1: one cycle from input pixel to output pixel
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> out_valid);
  a_r1_idle: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !out_valid);

  // R11: disabled cursor passes background
  a_r11_pass: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !cur_en) |=> (out_rgb == $past(pix_rgb)));

  // R9: nothing drawn at or past the right edge
  a_r9_clip: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !on_screen) |=> (out_rgb == $past(pix_rgb)));

  // R12: no overlay before the row fetch completes
  a_r12_wait: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !row_ok) |=> (out_rgb == $past(pix_rgb)));
endmodule

// File: rtl/hwcur_overlay.sv
module hwcur_overlay
  import hwcur_pkg::*;
#(
  parameter int unsigned ADDR_W = 27,
  parameter int unsigned X_W    = 14,
  parameter int unsigned Y_W    = 12,
  parameter int unsigned H_W    = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [H_W-1:0]    disp_hfield,
  input  logic [Y_W-1:0]    disp_vlast,
  input  logic              line_req,
  input  logic [Y_W-1:0]    line_y,
  input  logic              pix_valid,
  input  logic [X_W-1:0]    pix_x,
  input  logic [Y_W-1:0]    pix_y,
  input  logic [31:0]       pix_rgb,
  output logic              out_valid,
  output logic [31:0]       out_rgb,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);
  cur_cfg_t          cfg;
  logic              cur_en;
  logic [ADDR_W-1:0] start_addr;
  logic [5:0]        hot_x, hot_y;
  logic              row_ok;
  logic [Y_W-1:0]    row_y;
  logic [2:0]        byte_sel;
  logic [7:0]        and_byte, xor_byte;
  logic [X_W-1:0]    cur_x;
  logic [Y_W-1:0]    cur_y;

  hwcur_regs i_regs (
    .clk(clk), .rst(rst), .wr_en(reg_we), .wr_sel(reg_addr),
    .wr_data(reg_wdata), .cur_en(cur_en), .cfg_act(cfg)
  );

  assign hot_x      = cfg.hot[21:16];
  assign hot_y      = cfg.hot[5:0];
  assign cur_x      = cfg.pos[16 +: X_W];
  assign cur_y      = cfg.pos[0 +: Y_W];
  assign start_addr = cfg.base[ADDR_W-1:0] - ADDR_W'(hot_x) -
                      ADDR_W'({hot_y, 4'b0000});

  hwcur_fetch #(.ADDR_W(ADDR_W), .Y_W(Y_W)) i_fetch (
    .clk(clk), .rst(rst), .line_req(line_req), .line_y(line_y),
    .cur_en(cur_en), .cur_y(cur_y), .vis_last(disp_vlast),
    .start_addr(start_addr), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .row_ok(row_ok), .row_y(row_y),
    .byte_sel(byte_sel), .and_byte(and_byte), .xor_byte(xor_byte)
  );

  hwcur_blend #(.X_W(X_W), .Y_W(Y_W), .H_W(H_W)) i_blend (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_x(pix_x),
    .pix_y(pix_y), .pix_rgb(pix_rgb), .cur_en(cur_en), .cur_x(cur_x),
    .clr0(cfg.clr0), .clr1(cfg.clr1), .hfield(disp_hfield),
    .row_ok(row_ok), .row_y(row_y), .byte_sel(byte_sel),
    .and_byte(and_byte), .xor_byte(xor_byte),
    .out_valid(out_valid), .out_rgb(out_rgb)
  );
endmodule

// File: tb/test_hwcur_overlay.sv
module test_hwcur_overlay;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic clk = 0, rst = 1;
  logic reg_we = 0; logic [2:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic [10:0] disp_hfield = 11'd39; logic [11:0] disp_vlast = 12'd239;
  logic line_req = 0; logic [11:0] line_y = 0;
  logic pix_valid = 0; logic [13:0] pix_x = 0; logic [11:0] pix_y = 0;
  logic [31:0] pix_rgb = 0;
  logic out_valid; logic [31:0] out_rgb;
  logic mem_rd_en; logic [AW-1:0] mem_addr; logic [7:0] mem_rdata = 0;

  int n_tests = 0, n_fail = 0, rd_count = 0;
  bit done = 0;

  // bench model of the register state
  bit m_en;
  logic [31:0] p_base, p_pos, p_hot, a_base, a_pos, a_hot;
  logic [23:0] p_c0, p_c1, a_c0, a_c1;

  hwcur_overlay #(.ADDR_W(AW)) i_hwcur_overlay (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .disp_hfield(disp_hfield), .disp_vlast(disp_vlast),
    .line_req(line_req), .line_y(line_y), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .pix_rgb(pix_rgb), .out_valid(out_valid),
    .out_rgb(out_rgb), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memfn(logic [AW-1:0] a);
    logic [7:0] t;
    t = 8'(a * 29) + 8'h5A;
    return t ^ 8'(a >> 3);
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= memfn(mem_addr);
      rd_count  <= rd_count + 1;
    end
  end

  function automatic logic [31:0] bgf(int x, int y);
    return {8'h5A ^ 8'(y), 8'(x * 3), 8'(x + y), 8'(x)};
  endfunction

  function automatic bit in_rows(int y);
    int cy = int'(a_pos[11:0]);
    return m_en && y >= cy && y <= cy + 63 && y <= int'(disp_vlast);
  endfunction

  function automatic logic [31:0] expf(int x, int y);
    int cx = int'(a_pos[29:16]);
    int cy = int'(a_pos[11:0]);
    int w  = (int'(disp_hfield) + 1) * 8;
    logic [31:0] bg = bgf(x, y);
    logic [31:0] e32;
    logic [AW-1:0] ra;
    int col, row;
    bit ab, xb;
    if (!in_rows(y) || x < cx || x > cx + 63 || x >= w) return bg;
    e32 = (a_base & 32'h07FF_FFF0) - 32'(a_hot[21:16]) - 32'(a_hot[5:0]) * 16;
    row = y - cy; col = x - cx;
    ra = AW'(e32 + 32'(row * 16 + col / 8));
    ab = memfn(ra)[7 - col % 8];
    ra = AW'(e32 + 32'(row * 16 + 8 + col / 8));
    xb = memfn(ra)[7 - col % 8];
    if (ab && xb) return ~bg;
    if (ab) return bg;
    return {8'hFF, xb ? a_c1 : a_c0};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    case (a)
      3'd0: m_en = d[0];
      3'd1: p_base = d & 32'h87FF_FFF0;
      3'd2: p_pos  = d & 32'h3FFF_0FFF;
      3'd3: p_hot  = d & 32'h003F_003F;
      3'd4: p_c0   = d[23:0];
      3'd5: p_c1   = d[23:0];
      default: ;
    endcase
    if (!p_base[31]) begin
      a_base = p_base; a_pos = p_pos; a_hot = p_hot; a_c0 = p_c0; a_c1 = p_c1;
    end
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic stream(int y, int xs, int xe, string req);
    int bad = 0, fx = 0;
    logic [31:0] fa = 0, fe = 0;
    for (int x = xs; x <= xe; x++) begin
      pix_valid = 1; pix_x = 14'(x); pix_y = 12'(y); pix_rgb = bgf(x, y);
      @(negedge clk);
      if (out_valid !== 1'b1 || out_rgb !== expf(x, y)) begin
        if (bad == 0) begin fa = out_rgb; fe = expf(x, y); fx = x; end
        bad++;
      end
    end
    pix_valid = 0;
    @(negedge clk);
    chk(bad == 0, req, $sformatf("line %0d first bad x %0d", y, fx), fa, fe);
  endtask

  task automatic run_line(int y, int xs, int xe, string req);
    int er;
    rd_count = 0;
    line_req = 1; line_y = 12'(y);
    @(negedge clk);
    line_req = 0;
    repeat (24) @(negedge clk);
    er = in_rows(y) ? 16 : 0;
    chk(rd_count == er, req, $sformatf("row reads for line %0d", y), 32'(rd_count), 32'(er));
    stream(y, xs, xe, req);
  endtask

  task automatic t_reset();
    chk(out_valid === 1'b0 && mem_rd_en === 1'b0, "R1", "reset valid/read", {30'd0, out_valid, mem_rd_en}, 32'd0);
    chk(out_rgb === 32'd0, "R1", "reset pixel", out_rgb, 32'd0);
  endtask

  task automatic t_basic();
    wr(3'd1, 32'h0000_0100); wr(3'd2, {2'b0, 14'd10, 4'b0, 12'd5});
    wr(3'd4, 32'h0012_3456); wr(3'd5, 32'h00AB_CDEF); wr(3'd0, 32'd1);
    run_line(5, 0, 90, "R2 R3 R4 R5 first row");
    run_line(37, 0, 90, "R2 R3 R4 R5 middle row");
  endtask

  task automatic t_rows();
    run_line(68, 0, 90, "R10 last row");
    run_line(69, 0, 90, "R10 row below cursor");
    run_line(4, 0, 90, "R10 row above cursor");
  endtask

  task automatic t_hotspot();
    wr(3'd3, 32'h0003_0002);
    run_line(7, 0, 90, "R6 hotspot");
    wr(3'd1, 32'h0000_0000); wr(3'd3, 32'h0005_0003);
    run_line(6, 0, 90, "R6 hotspot wrap below zero");
    wr(3'd3, 32'h0);
  endtask

  task automatic t_masks();
    wr(3'd1, 32'h7800_034F); wr(3'd2, 32'hC000_F000 | {2'b0, 14'd20, 4'b0, 12'd9});
    wr(3'd4, 32'hEE65_4321); wr(3'd3, 32'hFFC0_FFC0);
    run_line(9, 0, 100, "R8 write masks");
  endtask

  task automatic t_lock();
    wr(3'd1, 32'h8000_0200); wr(3'd2, {2'b0, 14'd100, 4'b0, 12'd120});
    wr(3'd5, 32'h0011_2233);
    run_line(9, 0, 100, "R7 old settings held");
    run_line(120, 90, 170, "R7 pending position unused");
    wr(3'd1, 32'h0000_0200);
    run_line(120, 90, 170, "R7 applied on unlock");
  endtask

  task automatic t_clip();
    disp_hfield = 11'd14;
    wr(3'd2, {2'b0, 14'd100, 4'b0, 12'd5});
    run_line(5, 90, 170, "R9 right edge clip");
    disp_hfield = 11'd39;
  endtask

  task automatic t_vlast();
    disp_vlast = 12'd7;
    run_line(7, 90, 170, "R10 last visible line");
    run_line(8, 90, 170, "R10 below visible end");
    disp_vlast = 12'd239;
  endtask

  task automatic t_disable();
    wr(3'd0, 32'd0);
    run_line(5, 90, 170, "R11 disabled");
    wr(3'd0, 32'd1);
  endtask

  task automatic t_early();
    int bad = 0;
    logic [31:0] fa = 0, fe = 0;
    wr(3'd2, {2'b0, 14'd0, 4'b0, 12'd5}); wr(3'd4, 32'h0); wr(3'd5, 32'h0);
    line_req = 1; line_y = 12'd5;
    @(negedge clk);
    line_req = 0;
    for (int x = 0; x < 8; x++) begin
      pix_valid = 1; pix_x = 14'(x); pix_y = 12'd5; pix_rgb = bgf(x, 5);
      @(negedge clk);
      if (out_rgb !== bgf(x, 5)) begin
        if (bad == 0) begin fa = out_rgb; fe = bgf(x, 5); end
        bad++;
      end
    end
    pix_valid = 0;
    repeat (30) @(negedge clk);
    chk(bad == 0, "R12", "pixels before fetch done", fa, fe);
    stream(5, 0, 70, "R12 after fetch done");
  endtask

  initial begin
    m_en = 0; p_base = 0; p_pos = 0; p_hot = 0; p_c0 = 0; p_c1 = 0;
    a_base = 0; a_pos = 0; a_hot = 0; a_c0 = 0; a_c1 = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_rows();
    t_hotspot();
    t_masks();
    t_lock();
    t_clip();
    t_vlast();
    t_disable();
    t_early();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
    $finish;
  end
endmodule